// File: doc/BRIEF.md
# Streaming Window Scaler

The block multiplies a stream of complex samples by a stored window. Each stream beat holds one 32-bit sample: a signed 16-bit in-phase part in bits 31:16 and a signed 16-bit quadrature part in bits 15:0. Both parts are scaled by the same signed 16-bit coefficient, taken from an internal coefficient memory at the current window position. The scaled beat leaves on an output stream. It keeps its end-of-packet marker and has a fixed pipeline delay. When the output stalls, the input stalls too.

The window position steps once for every accepted input beat. It takes no account of packet boundaries and wraps only at the programmed window length. A small request/acknowledge register port sets that length and fills the coefficient memory. Each coefficient write goes to an auto-incrementing load pointer. Setting a new length restarts both the window position and the load pointer.

Top module: `win_scaler`

## Requirements
- R1: Synchronous active-high reset sets the window length to MAX_WIN, the window position and load pointer to 0, m_tvalid to 0 and resp_ack to 0.
- R2: Each output part equals (x * c + 16384) >>> 15, saturated to the range -32768..32767. Here x is the signed part from bits 31:16 (I) or 15:0 (Q) of the input beat, c is the signed coefficient, and the result goes back to the same bit field.
- R3: The first accepted beat after reset uses coefficient 0. Each later accepted beat uses the next entry. After entry (length-1) the position returns to 0. An input tlast does not restart the position.
- R4: m_tlast of each output beat equals s_tlast of the input beat it came from.
- R5: A write to address 0 with a value from 1 to MAX_WIN sets the window length and clears the window position and the load pointer. A read of address 0 returns the length.
- R6: A write to address 0 with 0 or with a value above MAX_WIN is ignored. Length, position and load pointer all stay unchanged.
- R7: A write to address 1 stores bits 15:0 at the load pointer. The pointer then steps by one and wraps to 0 after entry (length-1). A read of address 1 returns the load pointer.
- R8: Every read or write request, to any address, gets resp_ack high for exactly the next cycle. Reads of other addresses return 0, and writes to them change nothing.
- R9: With m_tready held high, a beat accepted at clock edge k shows m_tvalid high after edge k+2, and not earlier.
- R10: s_tready equals (!m_tvalid || m_tready). While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold. No beat is lost or repeated, and the position steps only on accepted beats.
- R11: If a beat is accepted in the same cycle as a coefficient write to the entry that beat reads, the beat uses the old coefficient. If a beat is accepted in the same cycle as a valid length write, the beat uses the old position and the next beat uses entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_wr | input | 1 | Register write request |
| req_rd | input | 1 | Register read request |
| req_addr | input | 20 | Register address |
| req_wdata | input | 32 | Register write data |
| resp_ack | output | 1 | Request acknowledge, one cycle after the request |
| resp_rdata | output | 32 | Read data, valid with resp_ack |
| s_tdata | input | 32 | Input sample, I in 31:16, Q in 15:0 |
| s_tlast | input | 1 | Input end of packet |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high with s_tvalid |
| m_tdata | output | 32 | Scaled sample, I in 31:16, Q in 15:0 |
| m_tlast | output | 1 | Output end of packet |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |

## Verification
Two kinds of same-cycle collision matter. The first is a coefficient write that hits the memory entry a beat is reading in that same cycle. The second is a length write, which restarts the position, landing in the same cycle as the position steps for an accepted beat. The bench starts a stream push and a register write in one forked step, so both reach the same clock edge. A behavioural model applies the stream step before the register effects and then predicts the read-first coefficient and the restarted position. Every output handshake is compared against the model's queue, and that queue also covers randomly stalled output.

// File: rtl/win_scaler_pkg.sv
package win_scaler_pkg;

  localparam int SMP_W = 16;
  localparam int PRD_W = 2 * SMP_W;

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [PRD_W-1:0] prd_t;

  // Q1.15 product back to 16 bits: round half upward, then clamp.
  function automatic smp_t round_sat(input prd_t p);
    logic signed [PRD_W:0] s;
    s = {p[PRD_W-1], p} + (PRD_W+1)'(1 << (SMP_W - 2));
    s = s >>> (SMP_W - 1);
    if (s > (PRD_W+1)'(32767))
      return smp_t'(16'h7fff);
    else if (s < -(PRD_W+1)'(32768))
      return smp_t'(16'h8000);
    else
      return smp_t'(s[SMP_W-1:0]);
  endfunction

endpackage

// File: rtl/win_scaler_ram.sv
module win_scaler_ram #(
  parameter int DEPTH = 4096,
  parameter int DW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Simple dual port, read-first on address collision.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/win_scaler_regs.sv
module win_scaler_regs #(
  parameter int MAX_WIN = 4096,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int COEF_W  = 16,
  localparam int IDX_W  = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1,
  localparam int SIZE_W = $clog2(MAX_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_ack,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [SIZE_W-1:0] win_size,
  output logic              idx_clr,
  output logic              cf_we,
  output logic [IDX_W-1:0]  cf_addr,
  output logic [COEF_W-1:0] cf_data
);

  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_COEF = ADDR_W'(1);

  logic [IDX_W-1:0] ld_ptr;
  logic             size_ok;

  assign size_ok = (req_wdata != '0) && (req_wdata <= DATA_W'(MAX_WIN));
  assign idx_clr = req_wr && (req_addr == A_SIZE) && size_ok;
  assign cf_we   = req_wr && (req_addr == A_COEF);
  assign cf_addr = ld_ptr;
  assign cf_data = req_wdata[COEF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_size <= SIZE_W'(MAX_WIN);
      ld_ptr   <= '0;
    end else if (idx_clr) begin
      win_size <= SIZE_W'(req_wdata);
      ld_ptr   <= '0;
    end else if (cf_we) begin
      if (SIZE_W'(ld_ptr) == win_size - SIZE_W'(1)) ld_ptr <= '0;
      else                                          ld_ptr <= ld_ptr + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_ack   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_ack   <= req_wr || req_rd;
      resp_rdata <= '0;
      if (req_rd) begin
        if (req_addr == A_SIZE)      resp_rdata <= DATA_W'(win_size);
        else if (req_addr == A_COEF) resp_rdata <= DATA_W'(ld_ptr);
      end
    end
  end

  p_ack_one_cycle_r8 : assert property (@(posedge clk) disable iff (rst)
    (req_wr || req_rd) |=> resp_ack);
  p_no_spurious_ack_r8 : assert property (@(posedge clk) disable iff (rst)
    !(req_wr || req_rd) |=> !resp_ack);
  p_bad_size_ignored_r6 : assert property (@(posedge clk) disable iff (rst)
    (req_wr && req_addr == A_SIZE && !size_ok) |=> $stable(win_size) && $stable(ld_ptr));
  p_size_legal_r5 : assert property (@(posedge clk) disable iff (rst)
    (win_size != '0) && (win_size <= SIZE_W'(MAX_WIN)));

endmodule

// File: rtl/win_scaler_pipe.sv
module win_scaler_pipe
  import win_scaler_pkg::*;
#(
  parameter int MAX_WIN = 4096,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1,
  localparam int SIZE_W = $clog2(MAX_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] win_size,
  input  logic              idx_clr,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_addr,
  input  smp_t              coef
);

  logic       en, acc;
  logic [IDX_W-1:0] idx;
  logic       va, la, vb, lb;
  smp_t       ai, aq;
  prd_t       pi, pq;

  assign en       = !m_tvalid || m_tready;
  assign acc      = s_tvalid && en;
  assign s_tready = en;
  assign rd_en    = en;
  assign rd_addr  = idx;

  // Window position: free running across packets, wraps at the length.
  always_ff @(posedge clk) begin
    if (rst || idx_clr)
      idx <= '0;
    else if (acc) begin
      if (SIZE_W'(idx) == win_size - SIZE_W'(1)) idx <= '0;
      else                                       idx <= idx + IDX_W'(1);
    end
  end

  // Stage A: capture sample alongside the coefficient read.
  always_ff @(posedge clk) begin
    if (rst) va <= 1'b0;
    else if (en) va <= s_tvalid;
    if (en) begin
      ai <= smp_t'(s_tdata[DATA_W-1 -: SMP_W]);
      aq <= smp_t'(s_tdata[SMP_W-1:0]);
      la <= s_tlast;
    end
  end

  // Stage B: full-precision products.
  always_ff @(posedge clk) begin
    if (rst) vb <= 1'b0;
    else if (en) vb <= va;
    if (en) begin
      pi <= ai * coef;
      pq <= aq * coef;
      lb <= la;
    end
  end

  // Stage C: round, saturate, register the output.
  always_ff @(posedge clk) begin
    if (rst) m_tvalid <= 1'b0;
    else if (en) m_tvalid <= vb;
    if (en) begin
      m_tdata <= {round_sat(pi), round_sat(pq)};
      m_tlast <= lb;
    end
  end

  p_idx_in_window_r3 : assert property (@(posedge clk) disable iff (rst)
    SIZE_W'(idx) < win_size);
  p_idx_still_r10 : assert property (@(posedge clk) disable iff (rst)
    (!acc && !idx_clr) |=> $stable(idx));
  p_hold_on_stall_r10 : assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));
  p_clear_wins_r11 : assert property (@(posedge clk) disable iff (rst)
    idx_clr |=> (idx == '0));

endmodule

// File: rtl/win_scaler.sv
module win_scaler
  import win_scaler_pkg::*;
#(
  parameter int MAX_WIN = 4096,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_ack,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready
);

  localparam int IDX_W  = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;
  localparam int SIZE_W = $clog2(MAX_WIN + 1);

  logic [SIZE_W-1:0] win_size;
  logic              idx_clr, cf_we, rd_en;
  logic [IDX_W-1:0]  cf_addr, rd_addr;
  logic [SMP_W-1:0]  cf_data, rd_data;

  win_scaler_regs #(
    .MAX_WIN (MAX_WIN),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .COEF_W  (SMP_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .req_wr     (req_wr),
    .req_rd     (req_rd),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .resp_ack   (resp_ack),
    .resp_rdata (resp_rdata),
    .win_size   (win_size),
    .idx_clr    (idx_clr),
    .cf_we      (cf_we),
    .cf_addr    (cf_addr),
    .cf_data    (cf_data)
  );

  win_scaler_ram #(
    .DEPTH (MAX_WIN),
    .DW    (SMP_W)
  ) u_ram (
    .clk   (clk),
    .we    (cf_we),
    .waddr (cf_addr),
    .wdata (cf_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  win_scaler_pipe #(
    .MAX_WIN (MAX_WIN),
    .DATA_W  (DATA_W)
  ) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .win_size (win_size),
    .idx_clr  (idx_clr),
    .s_tdata  (s_tdata),
    .s_tlast  (s_tlast),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .coef     (smp_t'(rd_data))
  );

  p_reset_quiet_r1 : assert property (@(posedge clk)
    rst |=> !m_tvalid && !resp_ack);

endmodule

// File: tb/test_win_scaler.sv
`timescale 1ns/1ps
module test_win_scaler;

  localparam int MAXW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_wr = 1'b0, req_rd = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_ack;
  logic [31:0] resp_rdata;
  logic [31:0] s_tdata = '0;
  logic        s_tlast = 1'b0, s_tvalid = 1'b0;
  logic        s_tready;
  logic [31:0] m_tdata;
  logic        m_tlast, m_tvalid;
  logic        m_tready = 1'b1;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit rnd_on = 0;
  logic [7:0] lfsr = 8'hA5;

  always #5 clk = ~clk;

  win_scaler #(.MAX_WIN(MAXW)) i_win_scaler (
    .clk(clk), .rst(rst),
    .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_ack(resp_ack), .resp_rdata(resp_rdata),
    .s_tdata(s_tdata), .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference
  int mc [MAXW];
  int m_win = MAXW, m_idx = 0, m_ptr = 0;
  logic [32:0] exp_q [$];
  bit   pend_ack = 0, pend_rd = 0;
  logic [31:0] pend_val = '0;
  string pend_tag = "R8";

  function automatic int rs(input int x, input int c);
    longint p;
    p = longint'(x) * longint'(c) + 64'sd16384;
    p = p >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  function automatic logic [31:0] scale(input logic [31:0] d, input int c);
    int i, q;
    i = rs(int'($signed(d[31:16])), c);
    q = rs(int'($signed(d[15:0])), c);
    return {i[15:0], q[15:0]};
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      pend_ack = 0; pend_rd = 0;
    end else begin
      bit acc, clr;
      logic [32:0] e;
      check(resp_ack == pend_ack, "R8 ack timing", resp_ack, pend_ack);
      if (pend_rd) check(resp_rdata == pend_val, pend_tag, resp_rdata, pend_val);
      check(s_tready == (!m_tvalid || m_tready), "R10 ready", s_tready, !m_tvalid || m_tready);
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) check(0, "R10 extra beat", m_tdata, 0);
        else begin
          e = exp_q.pop_front();
          check(m_tdata == e[31:0], "R2 R3 R11 data", m_tdata, e[31:0]);
          check(m_tlast == e[32], "R4 last", m_tlast, e[32]);
        end
      end
      acc = s_tvalid && s_tready;
      if (acc) exp_q.push_back({s_tlast, scale(s_tdata, mc[m_idx])});
      pend_ack = req_wr || req_rd;
      pend_rd  = req_rd;
      pend_val = 0;
      pend_tag = "R8 other read";
      if (req_rd && req_addr == 0) begin pend_val = m_win; pend_tag = "R5 R6 size read"; end
      if (req_rd && req_addr == 1) begin pend_val = m_ptr; pend_tag = "R7 ptr read"; end
      clr = req_wr && req_addr == 0 && req_wdata >= 1 && req_wdata <= MAXW;
      if (clr) m_idx = 0;
      else if (acc) m_idx = (m_idx == m_win - 1) ? 0 : m_idx + 1;
      if (req_wr && req_addr == 1) begin
        mc[m_ptr] = int'($signed(req_wdata[15:0]));
        m_ptr = (m_ptr == m_win - 1) ? 0 : m_ptr + 1;
      end
      if (clr) begin m_win = int'(req_wdata); m_ptr = 0; end
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_tready = rnd_on ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  task automatic reg_wr(input logic [19:0] a, input logic [31:0] d);
    req_wr = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_wr = 0;
  endtask

  task automatic reg_rd(input logic [19:0] a);
    req_rd = 1; req_addr = a;
    @(posedge clk); #1;
    req_rd = 0;
  endtask

  task automatic push(input logic [31:0] d, input logic l);
    bit ok;
    s_tdata = d; s_tlast = l; s_tvalid = 1;
    do begin
      @(negedge clk); ok = s_tready;
      @(posedge clk); #1;
    end while (!ok);
    s_tvalid = 0;
  endtask

  function automatic logic [31:0] pat(input int k);
    logic [31:0] v;
    v = 32'h9E37_79B9 * (k + 3);
    case (k % 7)
      0: v = 32'h8000_8000;
      1: v = 32'h7FFF_7FFF;
      2: v = 32'h4000_C000;
      default: ;
    endcase
    return v;
  endfunction

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < MAXW; k++) mc[k] = 0;
    idle(4);
    rst = 0;
    idle(1);
    // R1: reset state
    check(m_tvalid == 0, "R1 tvalid after reset", m_tvalid, 0);
    check(resp_ack == 0, "R1 ack after reset", resp_ack, 0);
    reg_rd(0);
    check(resp_rdata == MAXW, "R1 length after reset", resp_rdata, MAXW);
    reg_rd(1);
    check(resp_rdata == 0, "R1 pointer after reset", resp_rdata, 0);

    // R7: fill all entries, pointer wraps back to 0
    for (int k = 0; k < MAXW; k++) begin
      logic [15:0] c;
      c = 16'(k * 2731 - 20000);
      if (k == 0) c = 16'h8000;
      if (k == 1) c = 16'h7FFF;
      if (k == 2) c = 16'h4000;
      reg_wr(1, {16'hDEAD, c});
    end
    reg_rd(1);
    check(resp_rdata == 0, "R7 pointer wrap", resp_rdata, 0);

    // R3 R4: beats across packets, window wraps at 16
    for (int k = 0; k < 37; k++) push(pat(k), (k % 5) == 4);
    idle(6);

    // R9: latency with output ready
    push(32'h1234_5678, 1'b1);
    check(m_tvalid == 0, "R9 edge k", m_tvalid, 0);
    idle(1);
    check(m_tvalid == 0, "R9 edge k+1", m_tvalid, 0);
    idle(1);
    check(m_tvalid == 1, "R9 edge k+2", m_tvalid, 1);
    idle(4);

    // R5: shorter window, reload coefficients
    reg_wr(0, 4);
    reg_rd(0);
    check(resp_rdata == 4, "R5 length readback", resp_rdata, 4);
    for (int k = 0; k < 4; k++) reg_wr(1, 32'(16'(k * 9000 - 15000)));
    for (int k = 0; k < 10; k++) push(pat(k + 40), k == 9);

    // R6: bad lengths ignored, stream position continues
    reg_wr(0, 0);
    reg_wr(0, MAXW + 1);
    reg_rd(0);
    check(resp_rdata == 4, "R6 length kept", resp_rdata, 4);
    for (int k = 0; k < 3; k++) push(pat(k + 60), k == 2);

    // R8: unknown address
    reg_wr(20'h00005, 32'h0000_0007);
    reg_rd(20'h00005);
    check(resp_rdata == 0, "R8 unknown read", resp_rdata, 0);
    reg_rd(0);
    check(resp_rdata == 4, "R8 length untouched", resp_rdata, 4);

    // R10: random output stall
    rnd_on = 1;
    for (int k = 0; k < 60; k++) push(pat(k + 80), (k % 6) == 5);
    rnd_on = 0;
    idle(8);

    // R11: same-cycle collisions
    reg_wr(0, 4);
    fork
      push(32'h2000_E000, 1'b0);
      reg_wr(1, 32'h0000_7FFF);
    join
    for (int k = 0; k < 5; k++) push(pat(k + 150), 1'b0);
    fork
      push(32'h3000_D000, 1'b0);
      reg_wr(0, 3);
    join
    for (int k = 0; k < 4; k++) push(pat(k + 170), k == 3);
    idle(10);

    check(exp_q.size() == 0, "R10 no lost beat", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule